// File: doc/BRIEF.md
# Register Rename Map and Free Tag Queue

This block renames architectural registers onto a larger pool of physical registers for an out-of-order core in which register values live only in a physical register file. It keeps, for every architectural register, the physical tag that currently holds its newest value and a ready bit for that tag. It also keeps a queue of physical tags that are not in use. A dispatching instruction looks up two source registers and receives their tags and ready bits. If it writes a register, it takes the tag at the front of the queue. That tag replaces the old mapping, and the displaced tag is returned so the reorder buffer can record it.

Completion broadcasts set the ready bit of any mapping that holds the completing tag. A source lookup made in the same cycle as a matching broadcast already sees the entry as ready. When an instruction retires, its recorded displaced tag goes back to the tail of the queue. Rollback undoes one instruction per cycle, youngest first. Each step restores the displaced mapping as ready and puts the undone instruction's tag back at the front of the queue, so that tag is handed out next.

The pool holds one physical register per architectural register plus one per reorder-buffer entry. Tag value 0 is reserved and never used as a mapping, so tags run from 1 up to the pool size.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i+1 with its ready bit set, and the queue holds tags ARCH_REGS+1 up to ARCH_REGS+ROB_ENTRIES, to be handed out in ascending order.
- R2: The two source lookups (`src1_tag`/`src1_rdy`, `src2_tag`/`src2_rdy`) report the current mapping of `disp_src1` and `disp_src2` combinationally, whether or not `disp_valid` is high, and they reflect the map as it stood before the same cycle's dispatch write.
- R3: An accepted dispatch with `disp_has_dst`=1 outputs the queue's front tag on `dst_tag` and the destination's prior tag on `dst_old_tag`. From the next cycle the destination maps to the new tag with its ready bit clear.
- R4: A dispatch with `disp_has_dst`=0 drives `dst_tag` and `dst_old_tag` to 0, takes no tag from the queue and leaves the map unchanged.
- R5: While the queue is empty, `disp_ready` is 0 for a dispatch that needs a destination and `dst_tag` is 0; a dispatch without a destination is still accepted.
- R6: When `cdb_valid` is high, every map entry holding `cdb_tag` has its ready bit set from the next cycle.
- R7: A source lookup whose mapped tag equals a broadcast `cdb_tag` in the same cycle reports ready.
- R8: A tag presented on `ret_tag` with `ret_valid` is appended at the tail of the queue and is handed out only after every tag already in the queue.
- R9: A rollback step (`rb_valid`) rewrites the map entry of `rb_dst` to `rb_old_tag` with ready set, and pushes `rb_new_tag` to the front of the queue so the next allocation returns it.
- R10: While `rb_valid` is high, `disp_ready` is 0 and no dispatch is accepted.
- R11: Tag 0 never appears as a source tag or as an allocated destination tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_has_dst | input | 1 | Dispatching instruction writes a register |
| disp_dst | input | ARCH_W | Destination architectural register |
| disp_src1 | input | ARCH_W | First source architectural register |
| disp_src2 | input | ARCH_W | Second source architectural register |
| src1_tag | output | TAG_W | Physical tag mapped to the first source |
| src1_rdy | output | 1 | First source value is available |
| src2_tag | output | TAG_W | Physical tag mapped to the second source |
| src2_rdy | output | 1 | Second source value is available |
| dst_tag | output | TAG_W | Newly allocated tag (0 if none) |
| dst_old_tag | output | TAG_W | Tag displaced from the destination (0 if none) |
| cdb_valid | input | 1 | Completion broadcast valid |
| cdb_tag | input | TAG_W | Tag of the completing instruction |
| ret_valid | input | 1 | Retirement frees a tag |
| ret_tag | input | TAG_W | Displaced tag of the retiring instruction |
| rb_valid | input | 1 | Undo one instruction this cycle |
| rb_dst | input | ARCH_W | Destination of the undone instruction |
| rb_old_tag | input | TAG_W | Mapping to restore |
| rb_new_tag | input | TAG_W | Tag to return to the front of the queue |

## Verification
The hardest state to reach is an empty queue in which a retired tag and a rolled-back tag each sit in the queue, because allocations, a rollback and a retirement must come in a fixed order first. The bench allocates a tag, rolls that allocation back while a dispatch is pending, and allocates it again. It then retires a displaced tag and drains the queue with seven destination-writing dispatches. The queue's order then shows at `dst_tag`: the retired tag comes out last, after which a destination dispatch stalls and a store-like dispatch still goes through.

// File: rtl/rn_pkg.sv
// Package rn_pkg
// Default sizes shared by the rename block and its checker, plus the
// helper that gives the reset-time mapping of an architectural register.
package rn_pkg;
    localparam int ARCH_REGS_DEF   = 8;
    localparam int ROB_ENTRIES_DEF = 8;

    // Reset mapping: tag 0 is reserved, so register i sits on tag i+1.
    function automatic int rn_reset_tag(input int arch_idx);
        return arch_idx + 1;
    endfunction
endpackage

// File: rtl/rn_free_list.sv
// Module rn_free_list
// Circular queue of unallocated physical tags. Pops from the head, takes
// retired tags at the tail and returned (rolled back) tags at the head.
// Assumes: push_front and pop never occur in the same cycle, pop only when
// not empty, and the owner never pushes more tags than DEPTH in total.
module rn_free_list #(
    parameter int DEPTH    = 8,
    parameter int TAG_W    = 5,
    parameter int BASE_TAG = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    input  logic             push_back,
    input  logic [TAG_W-1:0] push_back_tag,
    input  logic             push_front,
    input  logic [TAG_W-1:0] push_front_tag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] head_inc, head_dec, tail_inc;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    // Neighbouring pointer positions used by the update process.
    always_comb begin
        head_inc = wrap_inc(head_q);
        head_dec = wrap_dec(head_q);
        tail_inc = wrap_inc(tail_q);
    end

    // Slot storage: preload with the spare tags, then write pushed tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= TAG_W'(BASE_TAG + i);
            end
        end else begin
            if (push_front) slots[head_dec] <= push_front_tag;
            if (push_back)  slots[tail_q]   <= push_back_tag;
        end
    end

    // Pointers and occupancy: starts full, head and tail both at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CNT_W'(DEPTH);
        end else begin
            if (push_front)  head_q <= head_dec;
            else if (pop)    head_q <= head_inc;
            if (push_back)   tail_q <= tail_inc;
            count_q <= count_q + CNT_W'(push_front) + CNT_W'(push_back)
                     - CNT_W'(pop);
        end
    end

    // Front-of-queue view.
    always_comb begin
        head_tag = slots[head_q];
        empty    = (count_q == '0);
    end
endmodule

// File: rtl/rn_map_table.sv
// Module rn_map_table
// One tag plus ready bit per architectural register, with NUM_RD bypassed
// lookup ports and one plain lookup of the destination's current tag.
// Write priority per entry: restore, then allocation, then broadcast set.
// Assumes: restore and allocation never target the same cycle.
module rn_map_table #(
    parameter int ARCH_REGS = 8,
    parameter int TAG_W     = 5,
    parameter int NUM_RD    = 2,
    parameter int ARCH_W    = $clog2(ARCH_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0][ARCH_W-1:0] rd_addr,
    output logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
    output logic [NUM_RD-1:0]             rd_rdy,
    input  logic [ARCH_W-1:0]             dst_addr,
    output logic [TAG_W-1:0]              dst_cur_tag,
    input  logic                          alloc_we,
    input  logic [TAG_W-1:0]              alloc_tag,
    input  logic                          cdb_valid,
    input  logic [TAG_W-1:0]              cdb_tag,
    input  logic                          restore_we,
    input  logic [ARCH_W-1:0]             restore_addr,
    input  logic [TAG_W-1:0]              restore_tag
);
    logic [TAG_W-1:0] ent_tag [ARCH_REGS];
    logic             ent_rdy [ARCH_REGS];

    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
        logic [TAG_W-1:0] tag_r;
        logic             rdy_r;

        // Entry state: reset mapping, then restore / allocate / wake-up.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r <= TAG_W'(rn_pkg::rn_reset_tag(g));
                rdy_r <= 1'b1;
            end else if (restore_we && restore_addr == ARCH_W'(g)) begin
                tag_r <= restore_tag;
                rdy_r <= 1'b1;
            end else if (alloc_we && dst_addr == ARCH_W'(g)) begin
                tag_r <= alloc_tag;
                rdy_r <= 1'b0;
            end else if (cdb_valid && cdb_tag == tag_r) begin
                rdy_r <= 1'b1;
            end
        end

        assign ent_tag[g] = tag_r;
        assign ent_rdy[g] = rdy_r;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_read
        // Lookup port with same-cycle broadcast bypass on the ready bit.
        always_comb begin
            rd_tag[p] = ent_tag[rd_addr[p]];
            rd_rdy[p] = ent_rdy[rd_addr[p]]
                      | (cdb_valid && cdb_tag == ent_tag[rd_addr[p]]);
        end
    end

    // Current mapping of the destination, reported as the displaced tag.
    always_comb begin
        dst_cur_tag = ent_tag[dst_addr];
    end
endmodule

// File: rtl/rn_rename_map.sv
// Module rn_rename_map
// Rename stage core: map table plus free tag queue. Dispatch is refused
// while a rollback step is in progress or when a destination is needed and
// the queue is empty. Retirement and rollback push tags into the queue.
// Assumes: the surrounding core only frees or returns tags it was given,
// and rolls back youngest first, one instruction per cycle.
module rn_rename_map #(
    parameter int ARCH_REGS   = rn_pkg::ARCH_REGS_DEF,
    parameter int ROB_ENTRIES = rn_pkg::ROB_ENTRIES_DEF,
    parameter int PHYS_REGS   = ARCH_REGS + ROB_ENTRIES,
    parameter int TAG_W       = $clog2(PHYS_REGS + 1),
    parameter int ARCH_W      = $clog2(ARCH_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic              disp_has_dst,
    input  logic [ARCH_W-1:0] disp_dst,
    input  logic [ARCH_W-1:0] disp_src1,
    input  logic [ARCH_W-1:0] disp_src2,
    output logic [TAG_W-1:0]  src1_tag,
    output logic              src1_rdy,
    output logic [TAG_W-1:0]  src2_tag,
    output logic              src2_rdy,
    output logic [TAG_W-1:0]  dst_tag,
    output logic [TAG_W-1:0]  dst_old_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic              rb_valid,
    input  logic [ARCH_W-1:0] rb_dst,
    input  logic [TAG_W-1:0]  rb_old_tag,
    input  logic [TAG_W-1:0]  rb_new_tag
);
    localparam int NUM_RD = 2;

    logic                          fl_empty;
    logic [TAG_W-1:0]              fl_head;
    logic                          alloc;
    logic [NUM_RD-1:0][ARCH_W-1:0] rd_addr;
    logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag;
    logic [NUM_RD-1:0]             rd_rdy;
    logic [TAG_W-1:0]              cur_dst_tag;

    // Acceptance and allocation decision for the dispatch slot.
    always_comb begin
        disp_ready = !rb_valid && (!disp_has_dst || !fl_empty);
        alloc      = disp_valid && disp_ready && disp_has_dst;
    end

    // Source lookup wiring and dispatch result outputs.
    always_comb begin
        rd_addr[0]  = disp_src1;
        rd_addr[1]  = disp_src2;
        src1_tag    = rd_tag[0];
        src1_rdy    = rd_rdy[0];
        src2_tag    = rd_tag[1];
        src2_rdy    = rd_rdy[1];
        dst_tag     = (disp_has_dst && !fl_empty) ? fl_head : '0;
        dst_old_tag = disp_has_dst ? cur_dst_tag : '0;
    end

    rn_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .TAG_W     (TAG_W),
        .NUM_RD    (NUM_RD),
        .ARCH_W    (ARCH_W)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_addr      (rd_addr),
        .rd_tag       (rd_tag),
        .rd_rdy       (rd_rdy),
        .dst_addr     (disp_dst),
        .dst_cur_tag  (cur_dst_tag),
        .alloc_we     (alloc),
        .alloc_tag    (fl_head),
        .cdb_valid    (cdb_valid),
        .cdb_tag      (cdb_tag),
        .restore_we   (rb_valid),
        .restore_addr (rb_dst),
        .restore_tag  (rb_old_tag)
    );

    rn_free_list #(
        .DEPTH    (ROB_ENTRIES),
        .TAG_W    (TAG_W),
        .BASE_TAG (ARCH_REGS + 1)
    ) u_free (
        .clk            (clk),
        .rst_n          (rst_n),
        .pop            (alloc),
        .head_tag       (fl_head),
        .empty          (fl_empty),
        .push_back      (ret_valid),
        .push_back_tag  (ret_tag),
        .push_front     (rb_valid),
        .push_front_tag (rb_new_tag)
    );
endmodule

// File: rtl/rn_rename_checker.sv
// Module rn_rename_checker
// Port-level properties of rn_rename_map. Tracks the number of tags held
// outside the queue with its own counter to check the stall rule.
module rn_rename_checker #(
    parameter int ROB_ENTRIES = 8,
    parameter int TAG_W       = 5,
    parameter int ARCH_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic              disp_has_dst,
    input logic [TAG_W-1:0]  src1_tag,
    input logic              src1_rdy,
    input logic [TAG_W-1:0]  src2_tag,
    input logic [TAG_W-1:0]  dst_tag,
    input logic [TAG_W-1:0]  dst_old_tag,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic              ret_valid,
    input logic              rb_valid
);
    localparam int LIVE_W = $clog2(ROB_ENTRIES + 1) + 1;

    logic [LIVE_W-1:0] live_q;
    logic              took;

    assign took = disp_valid && disp_ready && disp_has_dst;

    // Tags handed out and not yet given back.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_q + LIVE_W'(took) - LIVE_W'(ret_valid)
                            - LIVE_W'(rb_valid);
    end

    assert_live_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_has_dst && disp_ready) |-> (live_q < LIVE_W'(ROB_ENTRIES)));

    assert_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> (dst_tag != dst_old_tag));

    assert_no_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_has_dst |-> (dst_tag == '0 && dst_old_tag == '0));

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && cdb_tag == src1_tag) |-> src1_rdy);

    assert_rb_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> !disp_ready);

    assert_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (src1_tag != '0) && (src2_tag != '0) && (!took || dst_tag != '0));
endmodule

bind rn_rename_map rn_rename_checker #(
    .ROB_ENTRIES (ROB_ENTRIES),
    .TAG_W       (TAG_W),
    .ARCH_W      (ARCH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .disp_has_dst (disp_has_dst),
    .src1_tag     (src1_tag),
    .src1_rdy     (src1_rdy),
    .src2_tag     (src2_tag),
    .dst_tag      (dst_tag),
    .dst_old_tag  (dst_old_tag),
    .cdb_valid    (cdb_valid),
    .cdb_tag      (cdb_tag),
    .ret_valid    (ret_valid),
    .rb_valid     (rb_valid)
);

// File: tb/sim_rn_rename_map.sv
// Directed bench for rn_rename_map with default sizes (8 arch, 8 ROB).
module sim_rn_rename_map;
    localparam int AW = 3;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0, disp_has_dst = 1'b0;
    logic [AW-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
    logic          cdb_valid = 1'b0, ret_valid = 1'b0, rb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0, ret_tag = '0, rb_old_tag = '0, rb_new_tag = '0;
    logic [AW-1:0] rb_dst = '0;
    logic          disp_ready, src1_rdy, src2_rdy;
    logic [TW-1:0] src1_tag, src2_tag, dst_tag, dst_old_tag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rn_rename_map u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_has_dst(disp_has_dst), .disp_dst(disp_dst), .disp_src1(disp_src1),
        .disp_src2(disp_src2), .src1_tag(src1_tag), .src1_rdy(src1_rdy),
        .src2_tag(src2_tag), .src2_rdy(src2_rdy), .dst_tag(dst_tag),
        .dst_old_tag(dst_old_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .rb_valid(rb_valid),
        .rb_dst(rb_dst), .rb_old_tag(rb_old_tag), .rb_new_tag(rb_new_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Move to the drive point and clear every request.
    task automatic idle_slot();
        @(negedge clk);
        disp_valid = 0; disp_has_dst = 0; cdb_valid = 0;
        ret_valid = 0; rb_valid = 0;
    endtask

    task automatic set_disp(input logic v, input logic hd, input int d,
                            input int s1, input int s2);
        disp_valid = v; disp_has_dst = hd;
        disp_dst = AW'(d); disp_src1 = AW'(s1); disp_src2 = AW'(s2);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            idle_slot();
            set_disp(0, 0, 0, i, 7 - i);
            #2;
            chk("R1 src1 tag", src1_tag, i + 1);
            chk("R1 src1 rdy", src1_rdy, 1);
            chk("R1 src2 tag", src2_tag, 8 - i);
        end
    endtask

    task automatic t_alloc();
        idle_slot();
        set_disp(1, 1, 1, 1, 5);
        #2;
        chk("R3 ready", disp_ready, 1);
        chk("R2 pre-write src1 tag", src1_tag, 2);
        chk("R2 src2 tag", src2_tag, 6);
        chk("R3 dst tag", dst_tag, 9);
        chk("R3 old tag", dst_old_tag, 2);
        @(posedge clk);
        idle_slot();
        set_disp(0, 0, 0, 1, 0);
        #2;
        chk("R3 new map tag", src1_tag, 9);
        chk("R3 new map rdy", src1_rdy, 0);
    endtask

    task automatic t_no_dst();
        idle_slot();
        set_disp(1, 0, 1, 1, 1);
        #2;
        chk("R4 ready", disp_ready, 1);
        chk("R4 dst tag", dst_tag, 0);
        chk("R4 old tag", dst_old_tag, 0);
        @(posedge clk);
        idle_slot();
        set_disp(0, 0, 0, 1, 1);
        #2;
        chk("R4 map kept", src1_tag, 9);
        chk("R4 rdy kept", src1_rdy, 0);
    endtask

    task automatic t_wakeup();
        idle_slot();
        set_disp(0, 0, 0, 1, 0);
        cdb_valid = 1; cdb_tag = 9;
        #2;
        chk("R7 bypass rdy", src1_rdy, 1);
        chk("R7 bypass tag", src1_tag, 9);
        @(posedge clk);
        idle_slot();
        set_disp(0, 0, 0, 1, 0);
        #2;
        chk("R6 held rdy", src1_rdy, 1);
        chk("R6 other entry", src2_tag, 1);
    endtask

    task automatic t_rollback();
        idle_slot();
        set_disp(1, 1, 3, 0, 0);
        #2;
        chk("R3 second dst tag", dst_tag, 10);
        chk("R3 second old tag", dst_old_tag, 4);
        @(posedge clk);
        idle_slot();
        set_disp(1, 1, 5, 3, 0);
        rb_valid = 1; rb_dst = 3; rb_old_tag = 4; rb_new_tag = 10;
        #2;
        chk("R10 blocked", disp_ready, 0);
        @(posedge clk);
        idle_slot();
        set_disp(0, 0, 0, 3, 5);
        #2;
        chk("R9 restored tag", src1_tag, 4);
        chk("R9 restored rdy", src1_rdy, 1);
        chk("R10 no map write", src2_tag, 6);
        idle_slot();
        set_disp(1, 1, 2, 0, 0);
        #2;
        chk("R9 front reuse", dst_tag, 10);
        chk("R9 old tag", dst_old_tag, 3);
        @(posedge clk);
    endtask

    task automatic t_retire_drain();
        idle_slot();
        ret_valid = 1; ret_tag = 2;
        @(posedge clk);
        for (int k = 0; k < 7; k++) begin
            int exp_old;
            idle_slot();
            set_disp(1, 1, k, 0, 0);
            #2;
            case (k)
                0: exp_old = 1;
                1: exp_old = 9;
                2: exp_old = 10;
                default: exp_old = k + 1;
            endcase
            chk("R8 order ready", disp_ready, 1);
            chk("R8 alloc order", dst_tag, (k < 6) ? 11 + k : 2);
            chk("R3 drain old tag", dst_old_tag, exp_old);
            chk("R11 nonzero", int'(dst_tag != 0), 1);
            @(posedge clk);
        end
        idle_slot();
        set_disp(1, 1, 7, 0, 0);
        #2;
        chk("R5 stall", disp_ready, 0);
        chk("R5 no tag", dst_tag, 0);
        @(posedge clk);
        idle_slot();
        set_disp(1, 0, 7, 7, 6);
        #2;
        chk("R5 no-dst accepted", disp_ready, 1);
        chk("R5 arch7 kept", src1_tag, 8);
        chk("R3 arch6 map", src2_tag, 2);
        @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_alloc();
        t_no_dst();
        t_wakeup();
        t_rollback();
        t_retire_drain();
        idle_slot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule